// File: doc/BRIEF.md
# Return-Instruction Double-Trap Flag Clearing Unit

This block works out how the machine-level status register and the virtual-supervisor status register change when a hart executes one of its three return instructions: the machine return, the supervisor return, or the return from debug mode. It handles only the supervisor double-trap flag and the debug-return clearing of the modify-privilege bit. The pipeline gives it the kind of return, the privilege and virtualization the hart is in now, and the privilege and virtualization the return goes back to. It also gives it the current contents of both status registers.

One cycle later the block presents the new privilege, the new virtualization bit and both status values together. A write enable goes with each status value. The new privilege and both register updates appear in the same cycle, so the privilege switch and its status side effects take effect as one atomic step. A parameter turns double-trap support off. With support off, the flag is never touched.

Top module: `xret_sdt_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, upd_valid, both write enables, new_priv, new_virt and both status outputs are all zero.
- R2: A cycle with ret_valid high and ret_kind of 00 (machine return), 01 (supervisor return) or 10 (debug return) produces upd_valid high one cycle later. In that same cycle new_priv and new_virt carry the target that was sampled. A cycle with ret_valid low, or with ret_kind 11, produces upd_valid low and both write enables low one cycle later.
- R3: A machine return whose target privilege is U (00), or whose target is virtualized, clears mstatus bit 24 (the double-trap flag) and raises mstatus_we.
- R4: A machine return or a debug return whose target is virtualized U clears vsstatus bit 24 and raises vsstatus_we.
- R5: A machine return to M (11), or to non-virtualized S (01), leaves both write enables low and both status values unchanged.
- R6: A supervisor return executed in virtualized S (current privilege 01, current virt 1) clears vsstatus bit 24 with vsstatus_we. It leaves mstatus_we low.
- R7: A supervisor return executed in non-virtualized S clears mstatus bit 24 with mstatus_we. It also clears vsstatus bit 24 with vsstatus_we only when the target is virtualized U.
- R8: A supervisor return executed outside S mode leaves both write enables low and both status values unchanged.
- R9: A debug return clears mstatus bit 24 when its target privilege is U or its target is virtualized.
- R10: A debug return whose target privilege is not M clears mstatus bit 17 (modify-privilege) and raises mstatus_we. A debug return to M leaves bit 17 as it was.
- R11: With DBLTRP_EN = 0, bit 24 of both outputs always equals the sampled input and vsstatus_we stays low. The bit 17 rule of R10 still applies.
- R12: Every status bit other than bits 24 and 17 passes from input to output unchanged on every accepted return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A return instruction retires this cycle |
| ret_kind | input | 2 | 00 machine, 01 supervisor, 10 debug, 11 reserved |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| cur_virt | input | 1 | Hart is currently virtualized |
| tgt_priv | input | 2 | Privilege the return goes back to |
| tgt_virt | input | 1 | Return target is virtualized |
| mstatus_in | input | XLEN | Current machine status value |
| vsstatus_in | input | XLEN | Current virtual-supervisor status value |
| upd_valid | output | 1 | Privilege switch and status updates present |
| new_priv | output | 2 | Privilege after the return |
| new_virt | output | 1 | Virtualization after the return |
| mstatus_out | output | XLEN | Updated machine status value |
| mstatus_we | output | 1 | Write mstatus_out |
| vsstatus_out | output | XLEN | Updated virtual-supervisor status value |
| vsstatus_we | output | 1 | Write vsstatus_out |

## Verification
Every result of this block is due exactly one clock edge after the return is presented. The privilege, the virtualization bit, both status values and both enables all land together. The driver applies one return per cycle at the falling edge and pushes its expected result into a queue. The monitor pops one entry per cycle just after the next rising edge and compares all fields of that single cycle. A result that arrives late, early or split across cycles therefore shows up as a mismatch. A second instance built with double-trap support off runs on the same stimulus, and its outputs go through the same comparison.

// File: rtl/xret_sdt_pkg.sv
package xret_sdt_pkg;

   localparam logic [1:0] RET_MRET = 2'b00;
   localparam logic [1:0] RET_SRET = 2'b01;
   localparam logic [1:0] RET_DRET = 2'b10;
   localparam logic [1:0] RET_RSVD = 2'b11;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   typedef struct packed {
      logic clr_m_sdt;
      logic clr_vs_sdt;
      logic clr_mprv;
      logic legal;
   } ret_action_t;

endpackage

// File: rtl/xret_sdt_rules.sv
module xret_sdt_rules
   import xret_sdt_pkg::*;
#(
   parameter bit DBLTRP_EN = 1'b1
) (
   input  logic [1:0]  kind,
   input  logic [1:0]  cur_priv,
   input  logic        cur_virt,
   input  logic [1:0]  tgt_priv,
   input  logic        tgt_virt,
   output ret_action_t act
);

   logic tgt_user;
   logic tgt_vu;
   logic raw_m;
   logic raw_vs;
   logic raw_mprv;
   logic raw_legal;
   logic sdt_m;
   logic sdt_vs;

   assign tgt_user = (tgt_priv == PRIV_U);
   assign tgt_vu   = tgt_user && tgt_virt;

   always_comb begin
      raw_m     = 1'b0;
      raw_vs    = 1'b0;
      raw_mprv  = 1'b0;
      raw_legal = 1'b1;
      case (kind)
         RET_MRET: begin
            raw_m  = tgt_user || tgt_virt;
            raw_vs = tgt_vu;
         end
         RET_SRET: begin
            if (cur_priv == PRIV_S) begin
               if (cur_virt) begin
                  raw_vs = 1'b1;
               end else begin
                  raw_m  = 1'b1;
                  raw_vs = tgt_vu;
               end
            end
         end
         RET_DRET: begin
            raw_m    = tgt_user || tgt_virt;
            raw_vs   = tgt_vu;
            raw_mprv = (tgt_priv != PRIV_M);
         end
         default: raw_legal = 1'b0;
      endcase
   end

   generate
      if (DBLTRP_EN) begin : g_dbltrp_on
         assign sdt_m  = raw_m;
         assign sdt_vs = raw_vs;
      end else begin : g_dbltrp_off
         assign sdt_m  = 1'b0;
         assign sdt_vs = 1'b0;
      end
   endgenerate

   assign act = {sdt_m, sdt_vs, raw_mprv, raw_legal};

endmodule

// File: rtl/xret_sdt_clear.sv
module xret_sdt_clear #(
   parameter int XLEN     = 64,
   parameter int SDT_BIT  = 24,
   parameter int MPRV_BIT = 17
) (
   input  logic [XLEN-1:0] val_in,
   input  logic            clr_sdt,
   input  logic            clr_mprv,
   output logic [XLEN-1:0] val_out
);

   logic [XLEN-1:0] kill;

   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         if (i == SDT_BIT) begin : g_sdt
            assign kill[i] = clr_sdt;
         end else if (i == MPRV_BIT) begin : g_mprv
            assign kill[i] = clr_mprv;
         end else begin : g_keep
            assign kill[i] = 1'b0;
         end
      end
   endgenerate

   assign val_out = val_in & ~kill;

endmodule

// File: rtl/xret_sdt_stage.sv
module xret_sdt_stage
   import xret_sdt_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  ret_action_t     act,
   input  logic [1:0]      priv_in,
   input  logic            virt_in,
   input  logic [XLEN-1:0] ms_next,
   input  logic [XLEN-1:0] vs_next,
   output logic            upd_valid,
   output logic [1:0]      priv_q,
   output logic            virt_q,
   output logic [XLEN-1:0] ms_q,
   output logic            ms_we,
   output logic [XLEN-1:0] vs_q,
   output logic            vs_we
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_valid <= 1'b0;
         priv_q    <= 2'b00;
         virt_q    <= 1'b0;
         ms_q      <= '0;
         ms_we     <= 1'b0;
         vs_q      <= '0;
         vs_we     <= 1'b0;
      end else begin
         upd_valid <= take;
         ms_we     <= take && (act.clr_m_sdt || act.clr_mprv);
         vs_we     <= take && act.clr_vs_sdt;
         if (take) begin
            priv_q <= priv_in;
            virt_q <= virt_in;
            ms_q   <= ms_next;
            vs_q   <= vs_next;
         end
      end
   end

endmodule

// File: rtl/xret_sdt_unit.sv
module xret_sdt_unit
   import xret_sdt_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int SDT_BIT   = 24,
   parameter int MPRV_BIT  = 17,
   parameter bit DBLTRP_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ret_valid,
   input  logic [1:0]      ret_kind,
   input  logic [1:0]      cur_priv,
   input  logic            cur_virt,
   input  logic [1:0]      tgt_priv,
   input  logic            tgt_virt,
   input  logic [XLEN-1:0] mstatus_in,
   input  logic [XLEN-1:0] vsstatus_in,
   output logic            upd_valid,
   output logic [1:0]      new_priv,
   output logic            new_virt,
   output logic [XLEN-1:0] mstatus_out,
   output logic            mstatus_we,
   output logic [XLEN-1:0] vsstatus_out,
   output logic            vsstatus_we
);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("xret_sdt_unit: XLEN must be at least 32");
      end
      if (SDT_BIT >= XLEN || MPRV_BIT >= XLEN) begin : g_bad_pos
         $error("xret_sdt_unit: field position outside the register");
      end
      if (SDT_BIT == MPRV_BIT) begin : g_bad_overlap
         $error("xret_sdt_unit: field positions overlap");
      end
   endgenerate

   ret_action_t     act;
   logic            take;
   logic [XLEN-1:0] ms_next;
   logic [XLEN-1:0] vs_next;

   xret_sdt_rules #(.DBLTRP_EN(DBLTRP_EN)) u_rules (
      .kind     (ret_kind),
      .cur_priv (cur_priv),
      .cur_virt (cur_virt),
      .tgt_priv (tgt_priv),
      .tgt_virt (tgt_virt),
      .act      (act)
   );

   assign take = ret_valid && act.legal;

   xret_sdt_clear #(.XLEN(XLEN), .SDT_BIT(SDT_BIT), .MPRV_BIT(MPRV_BIT)) u_clr_m (
      .val_in   (mstatus_in),
      .clr_sdt  (act.clr_m_sdt),
      .clr_mprv (act.clr_mprv),
      .val_out  (ms_next)
   );

   xret_sdt_clear #(.XLEN(XLEN), .SDT_BIT(SDT_BIT), .MPRV_BIT(MPRV_BIT)) u_clr_vs (
      .val_in   (vsstatus_in),
      .clr_sdt  (act.clr_vs_sdt),
      .clr_mprv (1'b0),
      .val_out  (vs_next)
   );

   xret_sdt_stage #(.XLEN(XLEN)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .act       (act),
      .priv_in   (tgt_priv),
      .virt_in   (tgt_virt),
      .ms_next   (ms_next),
      .vs_next   (vs_next),
      .upd_valid (upd_valid),
      .priv_q    (new_priv),
      .virt_q    (new_virt),
      .ms_q      (mstatus_out),
      .ms_we     (mstatus_we),
      .vs_q      (vsstatus_out),
      .vs_we     (vsstatus_we)
   );

endmodule

// File: rtl/xret_sdt_checker.sv
module xret_sdt_checker
   import xret_sdt_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int SDT_BIT   = 24,
   parameter int MPRV_BIT  = 17,
   parameter bit DBLTRP_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ret_valid,
   input logic [1:0]      ret_kind,
   input logic [1:0]      cur_priv,
   input logic            cur_virt,
   input logic [1:0]      tgt_priv,
   input logic            tgt_virt,
   input logic [XLEN-1:0] mstatus_in,
   input logic [XLEN-1:0] vsstatus_in,
   input logic            upd_valid,
   input logic [1:0]      new_priv,
   input logic            new_virt,
   input logic [XLEN-1:0] mstatus_out,
   input logic            mstatus_we,
   input logic [XLEN-1:0] vsstatus_out,
   input logic            vsstatus_we
);

   localparam logic [XLEN-1:0] KEEP = ~((XLEN'(1) << SDT_BIT) | (XLEN'(1) << MPRV_BIT));

   logic acc;
   logic dt_on;
   assign acc   = ret_valid && (ret_kind != RET_RSVD);
   assign dt_on = DBLTRP_EN;

   // R2
   p_enable_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |-> (!mstatus_we && !vsstatus_we));

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (upd_valid && new_priv == $past(tgt_priv) && new_virt == $past(tgt_virt)));

   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !upd_valid);

   // R3
   p_mret_msdt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_on && ret_valid && ret_kind == RET_MRET && (tgt_priv == PRIV_U || tgt_virt))
      |=> (mstatus_we && !mstatus_out[SDT_BIT]));

   // R4
   p_vu_vssdt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_on && ret_valid && (ret_kind == RET_MRET || ret_kind == RET_DRET)
       && tgt_priv == PRIV_U && tgt_virt)
      |=> (vsstatus_we && !vsstatus_out[SDT_BIT]));

   // R5
   p_mret_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_kind == RET_MRET && !tgt_virt && tgt_priv != PRIV_U)
      |=> (!mstatus_we && !vsstatus_we));

   // R6
   p_sret_vs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_on && ret_valid && ret_kind == RET_SRET && cur_priv == PRIV_S && cur_virt)
      |=> (vsstatus_we && !vsstatus_out[SDT_BIT] && !mstatus_we));

   // R7
   p_sret_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_on && ret_valid && ret_kind == RET_SRET && cur_priv == PRIV_S && !cur_virt)
      |=> (mstatus_we && !mstatus_out[SDT_BIT]));

   // R8
   p_sret_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_kind == RET_SRET && cur_priv != PRIV_S)
      |=> (!mstatus_we && !vsstatus_we));

   // R10
   p_dret_mprv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_kind == RET_DRET && tgt_priv != PRIV_M)
      |=> (mstatus_we && !mstatus_out[MPRV_BIT]));

   // R11
   p_nodt_vs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!dt_on && acc) |=> (!vsstatus_we
                          && vsstatus_out[SDT_BIT] == $past(vsstatus_in[SDT_BIT])
                          && mstatus_out[SDT_BIT] == $past(mstatus_in[SDT_BIT])));

   // R12
   p_passthru_r12: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ((mstatus_out & KEEP) == ($past(mstatus_in) & KEEP)
               && (vsstatus_out & KEEP) == ($past(vsstatus_in) & KEEP)));

endmodule

bind xret_sdt_unit xret_sdt_checker #(
   .XLEN(XLEN), .SDT_BIT(SDT_BIT), .MPRV_BIT(MPRV_BIT), .DBLTRP_EN(DBLTRP_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
   .cur_priv(cur_priv), .cur_virt(cur_virt), .tgt_priv(tgt_priv), .tgt_virt(tgt_virt),
   .mstatus_in(mstatus_in), .vsstatus_in(vsstatus_in), .upd_valid(upd_valid),
   .new_priv(new_priv), .new_virt(new_virt), .mstatus_out(mstatus_out),
   .mstatus_we(mstatus_we), .vsstatus_out(vsstatus_out), .vsstatus_we(vsstatus_we)
);

// File: tb/xret_sdt_unit_bench.sv
module xret_sdt_unit_bench;

   localparam int XW = 64;
   localparam logic [XW-1:0] SDT  = 64'h1 << 24;
   localparam logic [XW-1:0] MPRV = 64'h1 << 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ret_valid = 1'b0;
   logic [1:0]    ret_kind = 2'b00;
   logic [1:0]    cur_priv = 2'b00;
   logic          cur_virt = 1'b0;
   logic [1:0]    tgt_priv = 2'b00;
   logic          tgt_virt = 1'b0;
   logic [XW-1:0] ms_in = '0;
   logic [XW-1:0] vs_in = '0;

   logic          a_val, b_val, a_virt, b_virt, a_mwe, b_mwe, a_vwe, b_vwe;
   logic [1:0]    a_priv, b_priv;
   logic [XW-1:0] a_ms, b_ms, a_vs, b_vs;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   xret_sdt_unit #(.XLEN(XW), .DBLTRP_EN(1'b1)) u_xret_sdt_unit (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
      .cur_priv(cur_priv), .cur_virt(cur_virt), .tgt_priv(tgt_priv), .tgt_virt(tgt_virt),
      .mstatus_in(ms_in), .vsstatus_in(vs_in), .upd_valid(a_val), .new_priv(a_priv),
      .new_virt(a_virt), .mstatus_out(a_ms), .mstatus_we(a_mwe),
      .vsstatus_out(a_vs), .vsstatus_we(a_vwe));

   xret_sdt_unit #(.XLEN(XW), .DBLTRP_EN(1'b0)) u_xret_sdt_unit_nodt (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
      .cur_priv(cur_priv), .cur_virt(cur_virt), .tgt_priv(tgt_priv), .tgt_virt(tgt_virt),
      .mstatus_in(ms_in), .vsstatus_in(vs_in), .upd_valid(b_val), .new_priv(b_priv),
      .new_virt(b_virt), .mstatus_out(b_ms), .mstatus_we(b_mwe),
      .vsstatus_out(b_vs), .vsstatus_we(b_vwe));

   typedef struct packed {
      logic          val;
      logic [1:0]    priv;
      logic          virt;
      logic [XW-1:0] ms;
      logic          mwe;
      logic [XW-1:0] vs;
      logic          vwe;
   } exp_t;

   typedef struct {
      exp_t  a;
      exp_t  b;
      string tag;
   } item_t;

   item_t exp_q[$];

   function automatic exp_t model(bit en, bit v, logic [1:0] k, logic [1:0] cp, bit cv,
                                  logic [1:0] tp, bit tv, logic [XW-1:0] ms,
                                  logic [XW-1:0] vs);
      exp_t e;
      bit cm = 0, cvs = 0, cpr = 0;
      bit vu = (tp == 2'b00) && tv;
      e.val = v && (k != 2'b11);
      if (k == 2'b00 || k == 2'b10) begin
         cm  = (tp == 2'b00) || tv;
         cvs = vu;
      end
      if (k == 2'b10) cpr = (tp != 2'b11);
      if (k == 2'b01 && cp == 2'b01) begin
         if (cv) cvs = 1;
         else begin cm = 1; cvs = vu; end
      end
      if (!en) begin cm = 0; cvs = 0; end
      e.priv = tp;
      e.virt = tv;
      e.ms   = ms & ~(cm ? SDT : '0) & ~(cpr ? MPRV : '0);
      e.vs   = vs & ~(cvs ? SDT : '0);
      e.mwe  = e.val && (cm || cpr);
      e.vwe  = e.val && cvs;
      return e;
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [XW-1:0] act, logic [XW-1:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic drive(bit v, logic [1:0] k, logic [1:0] cp, bit cv, logic [1:0] tp, bit tv,
                        logic [XW-1:0] ms, logic [XW-1:0] vs, string tag);
      item_t it;
      @(negedge clk);
      ret_valid = v; ret_kind = k; cur_priv = cp; cur_virt = cv;
      tgt_priv = tp; tgt_virt = tv; ms_in = ms; vs_in = vs;
      it.a   = model(1'b1, v, k, cp, cv, tp, tv, ms, vs);
      it.b   = model(1'b0, v, k, cp, cv, tp, tv, ms, vs);
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic cmp(exp_t e, string tag, logic val, logic [1:0] pr, logic vt,
                      logic [XW-1:0] ms, logic mwe, logic [XW-1:0] vs, logic vwe);
      chk(val == e.val, tag, "upd_valid", XW'(val), XW'(e.val));
      chk(mwe == e.mwe && vwe == e.vwe, tag, "write enables",
          XW'({mwe, vwe}), XW'({e.mwe, e.vwe}));
      if (e.val) begin
         chk(pr == e.priv && vt == e.virt, tag, "new privilege",
             XW'({pr, vt}), XW'({e.priv, e.virt}));
         chk(ms == e.ms, tag, "mstatus_out", ms, e.ms);
         chk(vs == e.vs, tag, "vsstatus_out", vs, e.vs);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         cmp(it.a, it.tag, a_val, a_priv, a_virt, a_ms, a_mwe, a_vs, a_vwe);
         cmp(it.b, {"R11 ", it.tag}, b_val, b_priv, b_virt, b_ms, b_mwe, b_vs, b_vwe);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [XW-1:0] all_ms = 64'hF0F0_1234_0FFF_FFFF | SDT | MPRV;
      logic [XW-1:0] all_vs = 64'h0A0A_5678_01FF_FF00 | SDT;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs cleared under reset
      chk(!a_val && !a_mwe && !a_vwe && a_ms == '0 && a_vs == '0 && a_priv == 2'b00 && !a_virt,
          "R1", "reset state", a_ms, '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: first cycle after reset
      chk(!a_val && !a_mwe && !a_vwe && !b_val, "R1", "post-reset idle", XW'(a_val), '0);

      drive(1, 2'b00, 2'b11, 0, 2'b00, 0, all_ms, all_vs, "R3 mret to U");
      drive(1, 2'b00, 2'b11, 0, 2'b01, 1, all_ms, all_vs, "R3 mret to VS");
      drive(1, 2'b00, 2'b11, 0, 2'b00, 1, all_ms, all_vs, "R4 mret to VU");
      drive(1, 2'b00, 2'b11, 0, 2'b11, 0, all_ms, all_vs, "R5 mret to M");
      drive(1, 2'b00, 2'b11, 0, 2'b01, 0, all_ms, all_vs, "R5 mret to HS");
      drive(1, 2'b01, 2'b01, 1, 2'b00, 1, all_ms, all_vs, "R6 sret in VS");
      drive(1, 2'b01, 2'b01, 1, 2'b01, 1, all_ms, all_vs, "R6 sret in VS to VS");
      drive(1, 2'b01, 2'b01, 0, 2'b00, 1, all_ms, all_vs, "R7 sret in HS to VU");
      drive(1, 2'b01, 2'b01, 0, 2'b01, 0, all_ms, all_vs, "R7 sret in HS to HS");
      drive(1, 2'b01, 2'b11, 0, 2'b00, 1, all_ms, all_vs, "R8 sret in M");
      drive(1, 2'b01, 2'b00, 0, 2'b00, 0, all_ms, all_vs, "R8 sret in U");
      drive(1, 2'b10, 2'b11, 0, 2'b00, 0, all_ms, all_vs, "R9 dret to U");
      drive(1, 2'b10, 2'b11, 0, 2'b01, 1, all_ms, all_vs, "R9 dret to VS");
      drive(1, 2'b10, 2'b11, 0, 2'b00, 1, all_ms, all_vs, "R4 dret to VU");
      drive(1, 2'b10, 2'b11, 0, 2'b01, 0, all_ms, all_vs, "R10 dret to HS");
      drive(1, 2'b10, 2'b11, 0, 2'b11, 0, all_ms, all_vs, "R10 dret to M");
      drive(1, 2'b11, 2'b11, 0, 2'b00, 1, all_ms, all_vs, "R2 reserved kind");
      drive(0, 2'b00, 2'b11, 0, 2'b00, 0, all_ms, all_vs, "R2 no return");
      drive(1, 2'b00, 2'b11, 0, 2'b00, 1, ~all_ms, ~all_vs, "R12 inverted pattern");
      drive(1, 2'b10, 2'b11, 0, 2'b00, 1, '0, '0, "R12 zero pattern");
      for (int i = 0; i < 400; i++) begin
         drive(($urandom % 4) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
               2'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
               "R12 mixed");
      end
      for (int i = 0; i < 3; i++)
         drive(0, 2'b00, 2'b00, 0, 2'b00, 0, '0, '0, "R2 drain");
      repeat (3) @(posedge clk);
      #2;
      finish_run();
   end

endmodule